// File: doc/BRIEF.md
# Dual-Slot Macro Processor ALU

This block is the arithmetic stage of a small macro processor that issues two ALU operations per instruction word. Each slot picks two 32-bit source operands: a register, the zero source, its own 16-bit immediate sign-extended, the other slot's immediate sign-extended, a 32-bit constant built from both immediates, or one of two parameter words fetched by a neighbouring loader. It then computes one arithmetic, logical, shift, compare, multiply or bit-field result. Branches, loops, data-RAM access and state reads are handled by other blocks.

The two slots share one carry register. Slot 1 sees the carry value that slot 0 leaves behind within the same instruction, so a 64-bit add, a 64-bit subtract or a multiply whose high half is collected in the same word all take one issue. Results are registered: on the clock edge that captures an issued word, both results appear on the result ports, the destination registers are written and the carry register is updated. No state changes while the issue strobe is low.

The block has no sequencing of its own. It has one datapath state, `CAPTURE`, entered on any edge with `issue_i` high. The other state, `HOLD`, is entered on any edge with `issue_i` low and keeps every register unchanged.

Top module: `macro_alu_pair`

## Requirements
- R1: After reset both result ports, the carry register and every general register read as zero.
- R2: Source code values are: 0..NREGS-1 for a register, NREGS for zero, NREGS+1 for the slot's own immediate sign-extended, NREGS+2 for the other slot's immediate sign-extended, NREGS+3 for {imm0,imm1}, NREGS+4 for load0 and NREGS+5 for load1. Results show on res0_o/res1_o one edge after the issue, and they hold while issue_i is low.
- R3: ADD (op 0) writes x+y and puts its carry-out (0 or 1) in the carry register. ADDC (op 1) is legal only in slot 1 when slot 0 holds ADD, and it returns x+y+carry using slot 0's carry.
- R4: SUB (op 2) writes x-y and sets the carry to 1 when the result exceeds x unsigned. SUBB (op 3) is legal only in slot 1 with SUB in slot 0, and it returns x-y-carry.
- R5: MUL (op 4) multiplies signed and MULU (op 5) multiplies unsigned. Both return the low 32 bits and store the high 32 bits as the carry. MULH (op 6) returns the carry value in effect for its slot.
- R6: SLL (op 8), SRL (op 9) and SRA (op 10) shift x by y[4:0] only.
- R7: CLZ (op 7) counts the leading zeros of x and returns 32 for zero. AND (11), NAND (12), OR (13) and XOR (14) are bitwise.
- R8: MERGE (op 15) reads the slot's own immediate as dpos = imm[15:10], width = imm[9:5] and spos = imm[4:0]. It returns x with bits [dpos +: width] replaced by (y >> spos). A field placed at dpos 32 or above leaves x unchanged.
- R9: SLT (16, signed), SLTU (17), SLE (18, signed), SLEU (19) and SEQ (20) return 0xFFFFFFFF when true and 0 when false.
- R10: A destination of NREGS discards the write. If both slots name the same register, slot 1's value is kept.
- R11: Only ADD, SUB, MUL and MULU change the carry register. If both slots change it, slot 1's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Instruction word valid this cycle |
| op0_i | input | 5 | Slot 0 operation code |
| op1_i | input | 5 | Slot 1 operation code |
| srca0_i | input | SELW | Slot 0 first source select |
| srcb0_i | input | SELW | Slot 0 second source select |
| srca1_i | input | SELW | Slot 1 first source select |
| srcb1_i | input | SELW | Slot 1 second source select |
| dst0_i | input | SELW | Slot 0 destination register |
| dst1_i | input | SELW | Slot 1 destination register |
| imm0_i | input | 16 | Slot 0 immediate |
| imm1_i | input | 16 | Slot 1 immediate |
| load0_i | input | 32 | First loaded parameter |
| load1_i | input | 32 | Second loaded parameter |
| res0_o | output | 32 | Registered slot 0 result |
| res1_o | output | 32 | Registered slot 1 result |
| carry_o | output | 32 | Shared carry / high register |

## Verification
The bench targets the carry hand-off inside a single word. A design that registered slot 0's carry before slot 1 saw it would give ADDC, SUBB and a same-word MULH an off-by-one or stale result. Shift amounts of 33, a MERGE destination position above 31, CLZ of zero and a signed versus unsigned compare of 0xFFFFFFFF against 1 each catch a common slip: shifting by the full operand, wrapping the insert position, returning 31 or 0, or comparing with the wrong signedness. Same-destination writes, discarded zero-register writes and carry retention across logic ops catch port-priority and write-enable mistakes.

// File: rtl/macro_alu_pkg.sv
package macro_alu_pkg;
    localparam int DW   = 32;
    localparam int IMMW = 16;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDC  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBB  = 5'd3,
        OP_MUL   = 5'd4,
        OP_MULU  = 5'd5,
        OP_MULH  = 5'd6,
        OP_CLZ   = 5'd7,
        OP_SLL   = 5'd8,
        OP_SRL   = 5'd9,
        OP_SRA   = 5'd10,
        OP_AND   = 5'd11,
        OP_NAND  = 5'd12,
        OP_OR    = 5'd13,
        OP_XOR   = 5'd14,
        OP_MERGE = 5'd15,
        OP_SLT   = 5'd16,
        OP_SLTU  = 5'd17,
        OP_SLE   = 5'd18,
        OP_SLEU  = 5'd19,
        OP_SEQ   = 5'd20
    } alu_op_e;

    // datapath states: an edge either captures an issued word or holds
    typedef enum logic {
        ST_HOLD    = 1'b0,
        ST_CAPTURE = 1'b1
    } dp_state_e;
endpackage

// File: rtl/macro_alu_operand.sv
module macro_alu_operand
    import macro_alu_pkg::*;
#(
    parameter int NREGS = 24,
    parameter int SELW  = $clog2(NREGS + 6)
) (
    input  logic [SELW-1:0] sel,
    input  logic [DW-1:0]   reg_val,
    input  logic [IMMW-1:0] imm_own,
    input  logic [IMMW-1:0] imm_other,
    input  logic [IMMW-1:0] imm_hi,
    input  logic [IMMW-1:0] imm_lo,
    input  logic [DW-1:0]   load0,
    input  logic [DW-1:0]   load1,
    output logic [DW-1:0]   opnd
);
    localparam int SEL_ZERO  = NREGS;
    localparam int SEL_IMM   = NREGS + 1;
    localparam int SEL_PAIR  = NREGS + 2;
    localparam int SEL_IMM32 = NREGS + 3;
    localparam int SEL_LD0   = NREGS + 4;
    localparam int SEL_LD1   = NREGS + 5;

    always_comb begin
        opnd = '0;
        if (int'(sel) < NREGS)               opnd = reg_val;
        else if (int'(sel) == SEL_ZERO)      opnd = '0;
        else if (int'(sel) == SEL_IMM)       opnd = {{(DW-IMMW){imm_own[IMMW-1]}}, imm_own};
        else if (int'(sel) == SEL_PAIR)      opnd = {{(DW-IMMW){imm_other[IMMW-1]}}, imm_other};
        else if (int'(sel) == SEL_IMM32)     opnd = {imm_hi, imm_lo};
        else if (int'(sel) == SEL_LD0)       opnd = load0;
        else if (int'(sel) == SEL_LD1)       opnd = load1;
    end
endmodule

// File: rtl/macro_alu_core.sv
module macro_alu_core
    import macro_alu_pkg::*;
(
    input  alu_op_e         op,
    input  logic [DW-1:0]   x,
    input  logic [DW-1:0]   y,
    input  logic [IMMW-1:0] imm,
    input  logic [DW-1:0]   cin,
    output logic [DW-1:0]   res,
    output logic [DW-1:0]   cout
);
    function automatic logic [5:0] lead_zeros(logic [DW-1:0] v);
        logic [5:0] n;
        n = 6'(DW);
        for (int i = 0; i < DW; i++)
            if (v[i]) n = 6'(DW - 1 - i);
        return n;
    endfunction

    logic [DW:0]     add_w;
    logic [DW-1:0]   diff;
    logic [2*DW-1:0] sprod;
    logic [2*DW-1:0] uprod;
    logic [5:0]      m_dpos;
    logic [4:0]      m_bits;
    logic [4:0]      m_spos;
    logic [DW-1:0]   m_mask;
    logic [DW-1:0]   m_place;

    always_comb begin
        add_w   = {1'b0, x} + {1'b0, y};
        diff    = x - y;
        sprod   = {{DW{x[DW-1]}}, x} * {{DW{y[DW-1]}}, y};
        uprod   = {{DW{1'b0}}, x} * {{DW{1'b0}}, y};
        m_dpos  = imm[15:10];
        m_bits  = imm[9:5];
        m_spos  = imm[4:0];
        m_mask  = (DW'(1) << m_bits) - DW'(1);
        m_place = m_mask << m_dpos;
    end

    always_comb begin
        res  = '0;
        cout = cin;
        unique case (op)
            OP_ADD:   begin res = add_w[DW-1:0]; cout = DW'(add_w[DW]); end
            OP_ADDC:  res = x + y + cin;
            OP_SUB:   begin res = diff; cout = DW'(diff > x); end
            OP_SUBB:  res = x - y - cin;
            OP_MUL:   begin res = sprod[DW-1:0]; cout = sprod[2*DW-1:DW]; end
            OP_MULU:  begin res = uprod[DW-1:0]; cout = uprod[2*DW-1:DW]; end
            OP_MULH:  res = cin;
            OP_CLZ:   res = DW'(lead_zeros(x));
            OP_SLL:   res = x << y[4:0];
            OP_SRL:   res = x >> y[4:0];
            OP_SRA:   res = DW'($signed(x) >>> y[4:0]);
            OP_AND:   res = x & y;
            OP_NAND:  res = ~(x & y);
            OP_OR:    res = x | y;
            OP_XOR:   res = x ^ y;
            OP_MERGE: res = (x & ~m_place) | (((y >> m_spos) & m_mask) << m_dpos);
            OP_SLT:   res = ($signed(x) <  $signed(y)) ? '1 : '0;
            OP_SLTU:  res = (x <  y) ? '1 : '0;
            OP_SLE:   res = ($signed(x) <= $signed(y)) ? '1 : '0;
            OP_SLEU:  res = (x <= y) ? '1 : '0;
            OP_SEQ:   res = (x == y) ? '1 : '0;
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/macro_alu_regfile.sv
module macro_alu_regfile
    import macro_alu_pkg::*;
#(
    parameter int NREGS = 24,
    parameter int NWR   = 2,
    parameter int NRD   = 4,
    parameter int SELW  = $clog2(NREGS + 6)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we    [NWR],
    input  logic [SELW-1:0] waddr [NWR],
    input  logic [DW-1:0]   wdata [NWR],
    input  logic [SELW-1:0] raddr [NRD],
    output logic [DW-1:0]   rdata [NRD]
);
    logic [DW-1:0] regs [NREGS];

    // later write ports win; addresses at or above NREGS are dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREGS; r++) regs[r] <= '0;
        end else begin
            for (int p = 0; p < NWR; p++)
                if (we[p] && int'(waddr[p]) < NREGS)
                    regs[waddr[p]] <= wdata[p];
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (int'(raddr[g]) < NREGS) ? regs[raddr[g]] : '0;
    end
endmodule

// File: rtl/macro_alu_pair.sv
module macro_alu_pair
    import macro_alu_pkg::*;
#(
    parameter int NREGS = 24,
    parameter int SELW  = $clog2(NREGS + 6)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic [4:0]      op0_i,
    input  logic [4:0]      op1_i,
    input  logic [SELW-1:0] srca0_i,
    input  logic [SELW-1:0] srcb0_i,
    input  logic [SELW-1:0] srca1_i,
    input  logic [SELW-1:0] srcb1_i,
    input  logic [SELW-1:0] dst0_i,
    input  logic [SELW-1:0] dst1_i,
    input  logic [15:0]     imm0_i,
    input  logic [15:0]     imm1_i,
    input  logic [31:0]     load0_i,
    input  logic [31:0]     load1_i,
    output logic [31:0]     res0_o,
    output logic [31:0]     res1_o,
    output logic [31:0]     carry_o
);
    localparam int NSLOT = 2;
    localparam int NRD   = 2 * NSLOT;

    dp_state_e       state;
    logic [DW-1:0]   carry_q;
    logic [DW-1:0]   res_q   [NSLOT];
    logic [DW-1:0]   chain   [NSLOT+1];
    logic [DW-1:0]   res_d   [NSLOT];
    logic [SELW-1:0] raddr   [NRD];
    logic [DW-1:0]   rdata   [NRD];
    logic            we      [NSLOT];
    logic [SELW-1:0] waddr   [NSLOT];
    alu_op_e         ops     [NSLOT];
    logic [IMMW-1:0] imms    [NSLOT];

    always_comb begin
        ops[0]   = alu_op_e'(op0_i);
        ops[1]   = alu_op_e'(op1_i);
        imms[0]  = imm0_i;
        imms[1]  = imm1_i;
        raddr[0] = srca0_i;
        raddr[1] = srcb0_i;
        raddr[2] = srca1_i;
        raddr[3] = srcb1_i;
        waddr[0] = dst0_i;
        waddr[1] = dst1_i;
        state    = issue_i ? ST_CAPTURE : ST_HOLD;
        chain[0] = carry_q;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [DW-1:0] xa;
        logic [DW-1:0] yb;

        assign we[s] = (state == ST_CAPTURE);

        macro_alu_operand #(.NREGS(NREGS), .SELW(SELW)) u_opa (
            .sel(raddr[2*s]), .reg_val(rdata[2*s]),
            .imm_own(imms[s]), .imm_other(imms[NSLOT-1-s]),
            .imm_hi(imm0_i), .imm_lo(imm1_i),
            .load0(load0_i), .load1(load1_i), .opnd(xa)
        );
        macro_alu_operand #(.NREGS(NREGS), .SELW(SELW)) u_opb (
            .sel(raddr[2*s+1]), .reg_val(rdata[2*s+1]),
            .imm_own(imms[s]), .imm_other(imms[NSLOT-1-s]),
            .imm_hi(imm0_i), .imm_lo(imm1_i),
            .load0(load0_i), .load1(load1_i), .opnd(yb)
        );
        // slot s consumes the carry left by slot s-1 in the same word
        macro_alu_core u_core (
            .op(ops[s]), .x(xa), .y(yb), .imm(imms[s]),
            .cin(chain[s]), .res(res_d[s]), .cout(chain[s+1])
        );
    end

    macro_alu_regfile #(.NREGS(NREGS), .NWR(NSLOT), .NRD(NRD), .SELW(SELW)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(res_d),
        .raddr(raddr), .rdata(rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= '0;
            for (int s = 0; s < NSLOT; s++) res_q[s] <= '0;
        end else begin
            unique case (state)
                ST_CAPTURE: begin
                    carry_q <= chain[NSLOT];
                    for (int s = 0; s < NSLOT; s++) res_q[s] <= res_d[s];
                end
                ST_HOLD: ;
            endcase
        end
    end

    always_comb begin
        res0_o  = res_q[0];
        res1_o  = res_q[1];
        carry_o = carry_q;
    end
endmodule

// File: rtl/macro_alu_pair_chk.sv
module macro_alu_pair_chk
    import macro_alu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        issue_i,
    input logic [4:0]  op0_i,
    input logic [4:0]  op1_i,
    input logic [31:0] res0_o,
    input logic [31:0] res1_o,
    input logic [31:0] carry_o
);
    logic op0_setcmp;
    logic op0_carry;
    logic op1_carry;
    assign op0_setcmp = op0_i inside {5'(OP_SLT), 5'(OP_SLTU), 5'(OP_SLE), 5'(OP_SLEU), 5'(OP_SEQ)};
    assign op0_carry  = op0_i inside {5'(OP_ADD), 5'(OP_SUB), 5'(OP_MUL), 5'(OP_MULU)};
    assign op1_carry  = op1_i inside {5'(OP_ADD), 5'(OP_SUB), 5'(OP_MUL), 5'(OP_MULU)};

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> ($stable(res0_o) && $stable(res1_o) && $stable(carry_o)));

    assert_addc_pairing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op1_i == 5'(OP_ADDC)) |-> op0_i == 5'(OP_ADD));

    assert_subb_pairing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op1_i == 5'(OP_SUBB)) |-> op0_i == 5'(OP_SUB));

    assert_mulh_reads_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op0_i == 5'(OP_MULH)) |=> res0_o == $past(carry_o));

    assert_clz_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op0_i == 5'(OP_CLZ)) |=> res0_o <= 32'd32);

    assert_setcmp_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op0_setcmp) |=> (res0_o == 32'd0 || res0_o == 32'hFFFF_FFFF));

    assert_carry_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !op0_carry && !op1_carry) |=> $stable(carry_o));
endmodule

bind macro_alu_pair macro_alu_pair_chk u_chk (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op0_i(op0_i), .op1_i(op1_i),
    .res0_o(res0_o), .res1_o(res1_o), .carry_o(carry_o)
);

// File: tb/test_macro_alu_pair.sv
module test_macro_alu_pair;
    localparam int NREGS = 24;
    localparam int SELW  = 5;

    // operation codes
    localparam logic [4:0] K_ADD = 0, K_ADDC = 1, K_SUB = 2, K_SUBB = 3, K_MUL = 4,
        K_MULU = 5, K_MULH = 6, K_CLZ = 7, K_SLL = 8, K_SRL = 9, K_SRA = 10,
        K_AND = 11, K_NAND = 12, K_OR = 13, K_XOR = 14, K_MERGE = 15,
        K_SLT = 16, K_SLTU = 17, K_SLE = 18, K_SLEU = 19, K_SEQ = 20;
    // source codes
    localparam logic [4:0] S_ZERO = 24, S_IMM = 25, S_PAIR = 26, S_IMM32 = 27,
        S_LD0 = 28, S_LD1 = 29;

    logic clk = 0, rst_n = 0, issue = 0;
    logic [4:0] op0 = 0, op1 = 0, a0 = 0, b0 = 0, a1 = 0, b1 = 0, d0 = 0, d1 = 0;
    logic [15:0] im0 = 0, im1 = 0;
    logic [31:0] ld0 = 0, ld1 = 0;
    logic [31:0] r0, r1, cy;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    macro_alu_pair #(.NREGS(NREGS), .SELW(SELW)) i_macro_alu_pair (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .op0_i(op0), .op1_i(op1),
        .srca0_i(a0), .srcb0_i(b0), .srca1_i(a1), .srcb1_i(b1),
        .dst0_i(d0), .dst1_i(d1), .imm0_i(im0), .imm1_i(im1),
        .load0_i(ld0), .load1_i(ld1), .res0_o(r0), .res1_o(r1), .carry_o(cy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // issue one word at a negedge; outputs are valid at the next negedge
    task automatic word(input logic [4:0] o0, x0, y0, z0, o1, x1, y1, z1,
                        input logic [15:0] i0, i1, input logic [31:0] l0, l1);
        @(negedge clk);
        issue = 1; op0 = o0; a0 = x0; b0 = y0; d0 = z0;
        op1 = o1; a1 = x1; b1 = y1; d1 = z1;
        im0 = i0; im1 = i1; ld0 = l0; ld1 = l1;
        @(negedge clk);
        issue = 0;
    endtask

    task automatic load_pair(input logic [4:0] ra, input logic [31:0] va,
                             input logic [4:0] rb, input logic [31:0] vb);
        word(K_OR, S_IMM32, S_ZERO, ra, K_OR, S_LD1, S_ZERO, rb,
             va[31:16], va[15:0], 0, vb);
    endtask

    task automatic read_reg(input logic [4:0] ra, input logic [4:0] rb);
        word(K_OR, ra, S_ZERO, S_ZERO, K_OR, rb, S_ZERO, S_ZERO, 0, 0, 0, 0);
    endtask

    task automatic t_reset;
        check("R1 res0", r0, 0);
        check("R1 res1", r1, 0);
        check("R1 carry", cy, 0);
        read_reg(5'd3, 5'd23);
        check("R1 reg3", r0, 0);
        check("R1 reg23", r1, 0);
    endtask

    task automatic t_operands;
        word(K_OR, S_IMM, S_ZERO, S_ZERO, K_OR, S_PAIR, S_ZERO, S_ZERO, 16'h8001, 16'h0005, 0, 0);
        check("R2 own imm sext", r0, 32'hFFFF8001);
        check("R2 pair imm", r1, 32'hFFFF8001);
        word(K_OR, S_PAIR, S_ZERO, S_ZERO, K_OR, S_IMM32, S_ZERO, S_ZERO, 16'h8001, 16'h0005, 0, 0);
        check("R2 pair imm slot0", r0, 32'h00000005);
        check("R2 imm32", r1, 32'h80010005);
        word(K_OR, S_LD0, S_ZERO, S_ZERO, K_OR, S_LD1, S_ZERO, S_ZERO, 0, 0, 32'h1234ABCD, 32'hCAFEF00D);
        check("R2 load0", r0, 32'h1234ABCD);
        check("R2 load1", r1, 32'hCAFEF00D);
        @(negedge clk);
        @(negedge clk);
        check("R2 hold res0", r0, 32'h1234ABCD);
        check("R2 hold res1", r1, 32'hCAFEF00D);
    endtask

    task automatic t_add;
        load_pair(1, 32'hFFFFFFFF, 2, 1);
        load_pair(3, 5, 4, 7);
        word(K_ADD, 1, 2, S_ZERO, K_ADDC, 3, 4, S_ZERO, 0, 0, 0, 0);
        check("R3 add wrap", r0, 0);
        check("R3 addc with carry", r1, 13);
        check("R3 carry set", cy, 1);
        word(K_ADD, 2, 2, S_ZERO, K_ADDC, 3, 4, S_ZERO, 0, 0, 0, 0);
        check("R3 add", r0, 2);
        check("R3 addc no carry", r1, 12);
        check("R3 carry clear", cy, 0);
    endtask

    task automatic t_sub;
        word(K_SUB, 2, 1, S_ZERO, K_SUBB, 4, 3, S_ZERO, 0, 0, 0, 0);
        check("R4 sub wrap", r0, 2);
        check("R4 subb borrow", r1, 1);
        check("R4 borrow set", cy, 1);
        word(K_SUB, 4, 3, S_ZERO, K_SUBB, 4, 3, S_ZERO, 0, 0, 0, 0);
        check("R4 sub", r0, 2);
        check("R4 subb no borrow", r1, 2);
        check("R4 borrow clear", cy, 0);
    endtask

    task automatic t_mul;
        load_pair(5, 32'hFFFFFFFE, 6, 3);
        word(K_MUL, 5, 6, S_ZERO, K_MULH, S_ZERO, S_ZERO, S_ZERO, 0, 0, 0, 0);
        check("R5 mul low", r0, 32'hFFFFFFFA);
        check("R5 mulh same word", r1, 32'hFFFFFFFF);
        check("R5 mul high", cy, 32'hFFFFFFFF);
        word(K_MULU, 5, 6, S_ZERO, K_OR, S_ZERO, S_ZERO, S_ZERO, 0, 0, 0, 0);
        check("R5 mulu low", r0, 32'hFFFFFFFA);
        check("R5 mulu high", cy, 2);
        word(K_MULH, S_ZERO, S_ZERO, S_ZERO, K_OR, S_ZERO, S_ZERO, S_ZERO, 0, 0, 0, 0);
        check("R5 mulh later", r0, 2);
    endtask

    task automatic t_shift;
        load_pair(7, 32'h80000001, 7, 32'h80000001);
        word(K_SLL, 7, S_IMM, S_ZERO, K_SRA, 7, S_PAIR, S_ZERO, 16'h0021, 0, 0, 0);
        check("R6 sll by 33", r0, 32'h00000002);
        check("R6 sra by 33", r1, 32'hC0000000);
        word(K_SRL, 7, S_IMM, S_ZERO, K_SRL, 7, S_IMM, S_ZERO, 16'h0021, 16'h001F, 0, 0);
        check("R6 srl by 33", r0, 32'h40000000);
        check("R6 srl by 31", r1, 32'h00000001);
    endtask

    task automatic t_logic;
        load_pair(8, 32'hF0F01234, 9, 32'h0FF0FF00);
        word(K_AND, 8, 9, S_ZERO, K_NAND, 8, 9, S_ZERO, 0, 0, 0, 0);
        check("R7 and", r0, 32'h00F01200);
        check("R7 nand", r1, 32'hFF0FEDFF);
        word(K_OR, 8, 9, S_ZERO, K_XOR, 8, 9, S_ZERO, 0, 0, 0, 0);
        check("R7 or", r0, 32'hFFF0FF34);
        check("R7 xor", r1, 32'hFF00ED34);
        word(K_CLZ, 9, S_ZERO, S_ZERO, K_CLZ, S_ZERO, S_ZERO, S_ZERO, 0, 0, 0, 0);
        check("R7 clz", r0, 4);
        check("R7 clz zero", r1, 32);
    endtask

    task automatic t_merge;
        word(K_MERGE, 8, 9, S_ZERO, K_MERGE, 8, 9, S_ZERO, 16'h208C, 16'hA100, 0, 0);
        check("R8 merge insert", r0, 32'hF0F01F34);
        check("R8 merge dpos>31", r1, 32'hF0F01234);
    endtask

    task automatic t_compare;
        load_pair(10, 32'hFFFFFFFF, 11, 1);
        word(K_SLT, 10, 11, S_ZERO, K_SLTU, 10, 11, S_ZERO, 0, 0, 0, 0);
        check("R9 slt signed", r0, 32'hFFFFFFFF);
        check("R9 sltu", r1, 0);
        word(K_SLE, 11, 11, S_ZERO, K_SLEU, 11, 10, S_ZERO, 0, 0, 0, 0);
        check("R9 sle equal", r0, 32'hFFFFFFFF);
        check("R9 sleu", r1, 32'hFFFFFFFF);
        word(K_SEQ, 10, 11, S_ZERO, K_SEQ, 11, 11, S_ZERO, 0, 0, 0, 0);
        check("R9 seq false", r0, 0);
        check("R9 seq true", r1, 32'hFFFFFFFF);
    endtask

    task automatic t_dest;
        load_pair(12, 32'h11112222, 12, 32'h33334444);
        word(K_OR, S_IMM32, S_ZERO, S_ZERO, K_OR, S_LD1, S_ZERO, S_ZERO, 16'hAAAA, 16'h5555, 0, 32'h77776666);
        check("R10 discard res", r0, 32'hAAAA5555);
        read_reg(5'd12, 5'd13);
        check("R10 slot1 wins", r0, 32'h33334444);
        check("R10 neighbour untouched", r1, 0);
    endtask

    task automatic t_carry;
        check("R11 carry kept over logic", cy, 2);
        word(K_ADD, 1, 2, S_ZERO, K_SUB, 4, 3, S_ZERO, 0, 0, 0, 0);
        check("R11 slot1 carry wins", cy, 0);
        check("R11 sub result", r1, 2);
        word(K_ADD, 1, 2, S_ZERO, K_OR, S_ZERO, S_ZERO, S_ZERO, 0, 0, 0, 0);
        check("R11 slot0 carry", cy, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_operands();
        t_add();
        t_sub();
        t_mul();
        t_shift();
        t_logic();
        t_merge();
        t_compare();
        t_carry();
        t_dest();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule